// File: doc/BRIEF.md
# Modem Line Status Monitor with Change Flags

This block watches a set of asynchronous modem control inputs, four by default, and presents them to a host as one status word. Each input first passes through a flop synchroniser. The upper half of the word gives the present synchronised level of every line. The lower half holds one sticky change flag per line. A flag is set when its line changes, and it stays set until the host reads the word.

The host reads the word by pulsing a read strobe for one clock. That strobe clears every change flag on the next edge. The clear gives way to a change that is detected on the same edge, so no transition is lost. One selected line, by default line 3, uses a different rule: its flag is raised only on its trailing edge, when it drops from 1 to 0. A single interrupt request is high while any change flag is set and the interrupt enable is high.

Top module: `modem_status_monitor`

## Requirements
- R1: While reset is asserted and directly after it is released, `status_o` is all zero and `irq_o` is 0.
- R2: Bit 4+i of `status_o` equals the level of `line_in[i]`, delayed by the two-flop synchroniser. An input driven between two edges appears after the second rising edge that follows.
- R3: For lines 0 to 2, bit i of `status_o` is set after the third rising edge that follows any change of `line_in[i]`, in either direction.
- R4: A set change flag stays set while `rd_i` is low. A clock edge with `rd_i` high clears every flag whose line shows no newly detected change on that edge.
- R5: The flag of line 3 (bit 3) is set only when that line falls from 1 to 0. A rise from 0 to 1 leaves bit 3 unchanged.
- R6: A change that is detected on the same edge as a read leaves its flag set after that edge.
- R7: `irq_o` is 1 exactly when `irq_en_i` is 1 and at least one of bits 3 to 0 of `status_o` is 1. It follows `irq_en_i` without a clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | 4 | Asynchronous modem control inputs |
| rd_i | input | 1 | One-cycle strobe that marks a host read of the status word |
| irq_en_i | input | 1 | Enable for the change interrupt |
| status_o | output | 8 | {synchronised levels[3:0], change flags[3:0]} |
| irq_o | output | 1 | Interrupt request |

## Verification
A host read and a freshly detected line change can land on the same clock edge. In that case the clear and the set compete for the same flag, and the set must win. The bench forces this case directly. It toggles a line, waits the two synchroniser cycles, and then holds the read strobe high in exactly the cycle whose closing edge detects the change. It then expects the flag to still be set, and to clear only on a second read. Random stimulus also raises reads and toggles together many times, and a cycle-accurate bench model judges every such cycle.

// File: rtl/msr_pkg.sv
package msr_pkg;
   localparam int unsigned MSR_LINES_DEF  = 4;
   localparam int unsigned MSR_SYNC_DEF   = 2;

   typedef enum logic {
      EDGE_ANY   = 1'b0,
      EDGE_TRAIL = 1'b1
   } edge_mode_e;
endpackage

// File: rtl/msr_line_sync.sv
module msr_line_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   localparam int unsigned LAST = STAGES - 1;

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("msr_line_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("msr_line_sync: WIDTH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= async_i;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   endgenerate

   assign sync_o = stage_q[LAST];
endmodule

// File: rtl/msr_change_flag.sv
module msr_change_flag
   import msr_pkg::*;
#(
   parameter edge_mode_e MODE = EDGE_ANY
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic rd_i,
   output logic flag_o
);
   logic prev_q;
   logic flag_q;
   logic evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   generate
      if (MODE == EDGE_TRAIL) begin : g_trail
         assign evt = prev_q & ~lvl_i;
         AST_TRAIL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q) |-> $past(prev_q && !lvl_i));                      // R5
      end else begin : g_any
         assign evt = prev_q ^ lvl_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag_q <= 1'b0;
      else if (evt)  flag_q <= 1'b1;
      else if (rd_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> flag_q);                                                       // R6
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !evt) |=> !flag_q);                                           // R4
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !rd_i) |=> flag_q);                                         // R4
endmodule

// File: rtl/modem_status_monitor.sv
module modem_status_monitor
   import msr_pkg::*;
#(
   parameter int unsigned           N_LINES     = MSR_LINES_DEF,
   parameter int unsigned           SYNC_STAGES = MSR_SYNC_DEF,
   parameter logic [N_LINES-1:0]    TRAIL_MASK  = 4'b1000
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_LINES-1:0]     line_in,
   input  logic                   rd_i,
   input  logic                   irq_en_i,
   output logic [2*N_LINES-1:0]   status_o,
   output logic                   irq_o
);
   localparam int unsigned SW = 2 * N_LINES;

   logic [N_LINES-1:0] level;
   logic [N_LINES-1:0] flags;

   generate
      if (N_LINES < 1 || N_LINES > 8) begin : g_bad_lines
         $error("modem_status_monitor: N_LINES must be 1..8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("modem_status_monitor: SYNC_STAGES must be at least 2");
      end
   endgenerate

   msr_line_sync #(
      .WIDTH  (N_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (line_in),
      .sync_o  (level)
   );

   generate
      for (genvar g = 0; g < N_LINES; g++) begin : g_line
         localparam edge_mode_e LMODE = TRAIL_MASK[g] ? EDGE_TRAIL : EDGE_ANY;
         msr_change_flag #(.MODE(LMODE)) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (level[g]),
            .rd_i   (rd_i),
            .flag_o (flags[g])
         );
      end
   endgenerate

   assign status_o = {level, flags};
   assign irq_o    = irq_en_i & (|flags);

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en_i |-> !irq_o);                                                 // R7
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (status_o[N_LINES-1:0] != '0));                              // R7
   AST_FLAGS_SET_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en_i && status_o[N_LINES-1:0] != '0) |-> irq_o);                  // R7
   AST_LEVEL_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[SW-1:N_LINES] == $past(u_sync.stage_q[SYNC_STAGES-2]));       // R2
endmodule

// File: tb/modem_status_monitor_test.sv
module modem_status_monitor_test;
   localparam int          NL    = 4;
   localparam logic [3:0]  TRAIL = 4'b1000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] line_in = '0;
   logic       rd_i = 1'b0;
   logic       irq_en_i = 1'b1;
   logic [7:0] status_o;
   logic       irq_o;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   modem_status_monitor uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_in  (line_in),
      .rd_i     (rd_i),
      .irq_en_i (irq_en_i),
      .status_o (status_o),
      .irq_o    (irq_o)
   );

   // Bench model built from the requirements
   logic [3:0] m_s1, m_s2, m_pv, m_fl;

   function automatic logic [3:0] next_flags(logic [3:0] fl, logic [3:0] lv,
                                             logic [3:0] pv, logic rd);
      logic [3:0] r;
      for (int i = 0; i < NL; i++) begin
         logic ev;
         ev   = TRAIL[i] ? (pv[i] & ~lv[i]) : (pv[i] ^ lv[i]);
         r[i] = ev | (fl[i] & ~rd);
      end
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_pv <= '0; m_fl <= '0;
      end else begin
         m_s1 <= line_in;
         m_s2 <= m_s1;
         m_pv <= m_s2;
         m_fl <= next_flags(m_fl, m_s2, m_pv, rd_i);
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      chk("R2 level nibble", 32'(status_o[7:4]), 32'(m_s2));
      chk("R3 flag nibble",  32'(status_o[3:0]), 32'(m_fl));
      chk("R7 irq",          32'(irq_o), 32'(irq_en_i & (|m_fl)));
   endtask

   task automatic clear_read();
      rd_i = 1'b1; step(); rd_i = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk("R1 reset status", 32'(status_o), 32'h0);
      chk("R1 reset irq",    32'(irq_o), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 post-reset status", 32'(status_o), 32'h0);

      // R2/R3 timing on line 1
      line_in = 4'b0010;
      step(); step();
      chk("R2 level after two edges", 32'(status_o[5]), 32'h1);
      chk("R3 flag not yet",          32'(status_o[1]), 32'h0);
      step();
      chk("R3 flag after third edge", 32'(status_o[1]), 32'h1);
      chk("R7 irq with flag",         32'(irq_o), 32'h1);
      irq_en_i = 1'b0;
      #1 chk("R7 irq masked", 32'(irq_o), 32'h0);
      irq_en_i = 1'b1;
      // R4 sticky then cleared
      step(); step();
      chk("R4 flag sticky", 32'(status_o[1]), 32'h1);
      clear_read();
      chk("R4 flags cleared by read", 32'(status_o[3:0]), 32'h0);

      // R5 trailing-edge line
      line_in = 4'b1010;
      step(); step(); step(); step();
      chk("R5 level of line 3",  32'(status_o[7]), 32'h1);
      chk("R5 rise sets no flag", 32'(status_o[3]), 32'h0);
      line_in = 4'b0010;
      step(); step(); step();
      chk("R5 fall sets flag", 32'(status_o[3]), 32'h1);
      clear_read();

      // R6 change on the read edge
      line_in = 4'b0011;
      step(); step();
      rd_i = 1'b1;
      step();
      chk("R6 change during read kept", 32'(status_o[0]), 32'h1);
      step();
      rd_i = 1'b0;
      chk("R4 second read clears", 32'(status_o[0]), 32'h0);

      // Constrained random mix
      for (int n = 0; n < 3000; n++) begin
         if ($urandom_range(3) == 0) line_in = 4'($urandom);
         rd_i     = ($urandom_range(4) == 0);
         irq_en_i = ($urandom_range(7) != 0);
         step();
      end

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nchk++; nfail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end
endmodule